// File: doc/BRIEF.md
# Jagged-Placement 4x4 Byte Matrix Multiplier

This block multiplies two 4x4 matrices of 8-bit elements. Each matrix is carried whole in one 128-bit vector, so its rows never have to sit on matching byte columns. The block does not compute each output element with its own dot product. It skews operand A into a jagged layout once, at the start. It then makes four passes. In each pass it multiplies the skewed A lane by lane with B, shifts that partial vector by a whole number of rows, and adds it into a 128-bit accumulator. Between passes, every row of the skewed A turns by one byte. A final fixed permutation undoes the skew and gives the product.

A caller presents both operands and pulses `start` while the block is idle. `busy` stays high while the sequence runs. `done` pulses for one cycle when the result vector is ready. The result then holds until the next multiply completes. All arithmetic is modulo 256.

Top module: `mm_jag_matmul`

## Requirements
- R1: Byte lane 4*r+c (bits 8*(4*r+c)+7 down to 8*(4*r+c)) holds element row r, column c of every matrix vector. When `done` is high, `result` equals the matrix product A*B, with each element reduced modulo 256.
- R2: A start accepted at clock edge n makes `done` high right after edge n+13. That is 14 steps: one skew, four passes of three steps each, and one un-skew.
- R3: A start accepted while idle raises `busy` after the same edge. `busy` stays high until the edge that raises `done`, and `busy` is low whenever `done` is high.
- R4: `done` is high for exactly one cycle per multiply.
- R5: While `busy` is high, `start` is ignored, and so are changes on `a_in` and `b_in`. The run in progress finishes on schedule, with the operands captured at acceptance.
- R6: `result` changes only in the cycle in which `done` rises. At every other time it holds its value.
- R7: The accumulator clears on every accepted start. A multiply's result does not depend on earlier multiplies.
- R8: Lane arithmetic wraps. For two all-0xFF matrices, every result element is 0x04.
- R9: A multiply by the identity matrix returns the other operand unchanged. The identity has 0x01 in lanes 0, 5, 10 and 15 and zero elsewhere.
- R10: During and right after reset, `busy` and `done` are low and `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiply; sampled only while idle |
| a_in | input | 128 | Left operand, row-major, lane 4*r+c |
| b_in | input | 128 | Right operand, row-major, lane 4*r+c |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse marking a fresh result |
| result | output | 128 | Product A*B modulo 256, row-major |

## Verification
Any fault in the skew, the per-row byte turn or the pass-indexed vector shift moves partial products into the wrong lanes. It therefore appears as wrong `result` elements at the `done` pulse 14 cycles after start. Distinct-valued operands multiplied by the identity expose the exact displaced lanes. An accumulator that is not cleared shows up in the run that follows a nonzero product. A sequencer fault shows up at the ports as a `done` that arrives at the wrong edge, as a repeated or missing `done`, or as `busy` overlapping `done`.

// File: rtl/mm_jag_pkg.sv
// Package: shared step encoding and variant selectors for the jagged
// matrix multiplier. Assumes no other package defines these names.
package mm_jag_pkg;

    // Sequencer step: one skew step, three per pass, one un-skew step.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_ALIGN,
        ST_ACC,
        ST_UNJAG
    } mm_step_e;

    // Permutation variants for mm_jag_perm.
    localparam int PERM_JAG    = 0;
    localparam int PERM_ROWROT = 1;
    localparam int PERM_UNJAG  = 2;

    // Lane operation variants for mm_lane_arith.
    localparam int LANE_MUL = 0;
    localparam int LANE_ADD = 1;

endpackage

// File: rtl/mm_jag_perm.sv
// Module: fixed byte-lane permutation of a DIM x DIM matrix vector.
// MODE picks one of three wirings (lane index = DIM*row + col):
//   PERM_JAG    : out(r,c) = in((r+c) mod DIM, r)      skew of operand A
//   PERM_ROWROT : out(r,c) = in(r, (c+1) mod DIM)      one-lane turn per row
//   PERM_UNJAG  : out(x,y) = in((x-y) mod DIM, y)      recovery of product
// Assumes: pure wiring, no logic; DIM >= 2.
module mm_jag_perm
    import mm_jag_pkg::*;
#(
    parameter int DIM  = 4,
    parameter int EW   = 8,
    parameter int MODE = PERM_JAG
) (
    input  logic [DIM*DIM*EW-1:0] din,
    output logic [DIM*DIM*EW-1:0] dout
);

    // Route each destination lane from its source lane.
    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            localparam int DST = r * DIM + c;
            if (MODE == PERM_JAG) begin : g_jag
                localparam int SRC = ((r + c) % DIM) * DIM + r;
                assign dout[DST*EW +: EW] = din[SRC*EW +: EW];
            end else if (MODE == PERM_ROWROT) begin : g_rot
                localparam int SRC = r * DIM + ((c + 1) % DIM);
                assign dout[DST*EW +: EW] = din[SRC*EW +: EW];
            end else begin : g_unjag
                localparam int SRC = ((r - c + DIM) % DIM) * DIM + c;
                assign dout[DST*EW +: EW] = din[SRC*EW +: EW];
            end
        end
    end

endmodule

// File: rtl/mm_lane_arith.sv
// Module: lane-wise EW-bit arithmetic on two matrix vectors.
// OP selects LANE_MUL (product) or LANE_ADD (sum); both wrap modulo 2**EW.
// Assumes: purely combinational; carries never cross lanes.
module mm_lane_arith
    import mm_jag_pkg::*;
#(
    parameter int DIM = 4,
    parameter int EW  = 8,
    parameter int OP  = LANE_MUL
) (
    input  logic [DIM*DIM*EW-1:0] x,
    input  logic [DIM*DIM*EW-1:0] y,
    output logic [DIM*DIM*EW-1:0] z
);

    localparam int LANES = DIM * DIM;

    // One independent operator per lane, truncated to the lane width.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [EW-1:0] xl;
        logic [EW-1:0] yl;
        assign xl = x[l*EW +: EW];
        assign yl = y[l*EW +: EW];
        if (OP == LANE_MUL) begin : g_mul
            assign z[l*EW +: EW] = xl * yl;
        end else begin : g_add
            assign z[l*EW +: EW] = xl + yl;
        end
    end

endmodule

// File: rtl/mm_vec_rot.sv
// Module: whole-vector rotation by a variable number of rows.
// Row r of the output takes row (r - rows) mod DIM of the input, i.e. the
// vector rotates toward higher lanes by rows*DIM lanes.
// Assumes: rows < DIM.
module mm_vec_rot #(
    parameter int DIM = 4,
    parameter int EW  = 8,
    parameter int IW  = 2
) (
    input  logic [DIM*DIM*EW-1:0] din,
    input  logic [IW-1:0]         rows,
    output logic [DIM*DIM*EW-1:0] dout
);

    // Select every output row from its rotated source row.
    always_comb begin
        int src;
        dout = '0;
        for (int r = 0; r < DIM; r++) begin
            src = (r + DIM - int'(rows)) % DIM;
            dout[r*DIM*EW +: DIM*EW] = din[src*DIM*EW +: DIM*EW];
        end
    end

endmodule

// File: rtl/mm_jag_seq.sv
// Module: step sequencer. On an idle start it emits one load step,
// then DIM passes of multiply / align / accumulate, then one un-skew step,
// and then a registered one-cycle done.
// Assumes: start is ignored unless idle.
module mm_jag_seq
    import mm_jag_pkg::*;
#(
    parameter int DIM = 4,
    parameter int IW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          ld,
    output logic          en_mul,
    output logic          en_align,
    output logic          en_acc,
    output logic          en_out,
    output logic [IW-1:0] iter
);

    localparam logic [IW-1:0] LAST = IW'(DIM - 1);

    mm_step_e step_q;
    mm_step_e step_d;

    // Step decode into datapath enables.
    always_comb begin
        ld       = (step_q == ST_IDLE) && start;
        en_mul   = (step_q == ST_MUL);
        en_align = (step_q == ST_ALIGN);
        en_acc   = (step_q == ST_ACC);
        en_out   = (step_q == ST_UNJAG);
    end

    // Next-step selection.
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE:  if (start) step_d = ST_MUL;
            ST_MUL:   step_d = ST_ALIGN;
            ST_ALIGN: step_d = ST_ACC;
            ST_ACC:   step_d = (iter == LAST) ? ST_UNJAG : ST_MUL;
            ST_UNJAG: step_d = ST_IDLE;
            default:  step_d = ST_IDLE;
        endcase
    end

    // Step, pass counter and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            iter   <= '0;
            done   <= 1'b0;
        end else begin
            step_q <= step_d;
            done   <= en_out;
            if (ld)
                iter <= '0;
            else if (en_acc && iter != LAST)
                iter <= iter + 1'b1;
        end
    end

    assign busy = (step_q != ST_IDLE);

endmodule

// File: rtl/mm_jag_matmul.sv
// Module: top of the jagged-placement DIM x DIM matrix multiplier.
// Holds the skewed A, captured B, partial product, aligned partial,
// accumulator and result registers; the sequencer drives their enables.
// Assumes: row-major vectors with lane DIM*row+col, EW-bit elements.
module mm_jag_matmul
    import mm_jag_pkg::*;
#(
    parameter int DIM = 4,
    parameter int EW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DIM*DIM*EW-1:0] a_in,
    input  logic [DIM*DIM*EW-1:0] b_in,
    output logic                  busy,
    output logic                  done,
    output logic [DIM*DIM*EW-1:0] result
);

    localparam int VW = DIM * DIM * EW;
    localparam int IW = (DIM > 2) ? $clog2(DIM) : 1;

    logic          ld, en_mul, en_align, en_acc, en_out;
    logic [IW-1:0] iter;

    logic [VW-1:0] aj_q, b_q, prod_q, rot_q, acc_q, res_q;
    logic [VW-1:0] aj_init, aj_turn, prod_d, rot_d, acc_d, res_d;

    mm_jag_seq #(.DIM(DIM), .IW(IW)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done),
        .ld(ld), .en_mul(en_mul), .en_align(en_align),
        .en_acc(en_acc), .en_out(en_out), .iter(iter)
    );

    mm_jag_perm #(.DIM(DIM), .EW(EW), .MODE(PERM_JAG)) skew_i (
        .din(a_in), .dout(aj_init)
    );

    mm_jag_perm #(.DIM(DIM), .EW(EW), .MODE(PERM_ROWROT)) turn_i (
        .din(aj_q), .dout(aj_turn)
    );

    mm_lane_arith #(.DIM(DIM), .EW(EW), .OP(LANE_MUL)) mul_i (
        .x(aj_q), .y(b_q), .z(prod_d)
    );

    mm_vec_rot #(.DIM(DIM), .EW(EW), .IW(IW)) align_i (
        .din(prod_q), .rows(iter), .dout(rot_d)
    );

    mm_lane_arith #(.DIM(DIM), .EW(EW), .OP(LANE_ADD)) add_i (
        .x(acc_q), .y(rot_q), .z(acc_d)
    );

    mm_jag_perm #(.DIM(DIM), .EW(EW), .MODE(PERM_UNJAG)) unskew_i (
        .din(acc_q), .dout(res_d)
    );

    // Operand capture, skewed-A turning and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aj_q  <= '0;
            b_q   <= '0;
            acc_q <= '0;
        end else if (ld) begin
            aj_q  <= aj_init;
            b_q   <= b_in;
            acc_q <= '0;
        end else if (en_acc) begin
            aj_q  <= aj_turn;
            acc_q <= acc_d;
        end
    end

    // Partial product and its row-aligned copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            rot_q  <= '0;
        end else begin
            if (en_mul)   prod_q <= prod_d;
            if (en_align) rot_q  <= rot_d;
        end
    end

    // Result register, written only on the un-skew step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (en_out)
            res_q <= res_d;
    end

    assign result = res_q;

endmodule

// File: rtl/mm_jag_matmul_chk.sv
// Module: protocol checker for mm_jag_matmul, bound to every instance.
// Counts the cycles since an accepted start to check the completion edge.
module mm_jag_matmul_chk #(
    parameter int DIM = 4,
    parameter int EW  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [DIM*DIM*EW-1:0] result
);

    localparam int STEPS = 2 + 3 * DIM;
    localparam int CW    = $clog2(STEPS + 2) + 1;

    logic [CW-1:0] cnt;

    // Cycles elapsed since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start && !busy)
            cnt <= CW'(1);
        else if (busy)
            cnt <= cnt + 1'b1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == CW'(STEPS)));

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind mm_jag_matmul mm_jag_matmul_chk #(.DIM(DIM), .EW(EW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .result(result)
);

// File: tb/mm_jag_matmul_tb_top.sv
// Bench: directed corner matrices plus seeded random operands, each
// result compared with a behavioural 4x4 product modulo 256.
module mm_jag_matmul_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] a_in = '0;
    logic [127:0] b_in = '0;
    logic         busy;
    logic         done;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    localparam logic [127:0] IDENT = 128'h01000000_00010000_00000100_00000001;
    localparam logic [127:0] SEQV  = 128'h100f0e0d_0c0b0a09_08070605_04030201;

    always #4 clk = ~clk;

    mm_jag_matmul dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .result(result)
    );

    // Behavioural product modulo 256, lane 4*r+c.
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [7:0] s = 8'h00;
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] ea = a[(4*i+k)*8 +: 8];
                    logic [7:0] eb = b[(4*k+j)*8 +: 8];
                    s = s + ea * eb;
                end
                r[(4*i+j)*8 +: 8] = s;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // One multiply; optional disturbance of inputs and start while busy (R5).
    task automatic do_mul(input logic [127:0] ma, input logic [127:0] mb,
                          input bit disturb, input string tag);
        int n;
        logic [127:0] exp;
        logic [127:0] held;
        exp = ref_mul(ma, mb);
        @(negedge clk);
        a_in = ma; b_in = mb; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n = 1;
        chk(busy === 1'b1, "R3 busy after accept", 128'(busy), 128'd1);
        if (disturb) begin
            a_in = ~ma; b_in = ma ^ mb; start = 1'b1;
            @(negedge clk);
            n++;
            a_in = rnd128(); start = 1'b1;
            @(negedge clk);
            n++;
            start = 1'b0;
        end
        while (!done && n < 64) begin
            @(negedge clk);
            n++;
        end
        chk(n == 14, {"R2 latency ", tag}, 128'(n), 128'd14);
        chk(result === exp, {"R1 product ", tag}, result, exp);
        chk(busy === 1'b0, "R3 busy low with done", 128'(busy), 128'd0);
        held = result;
        a_in = rnd128(); b_in = rnd128();
        @(negedge clk);
        chk(done === 1'b0, "R4 done single cycle", 128'(done), 128'd0);
        repeat (3) @(negedge clk);
        chk(result === held, "R6 result held", result, held);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R10 busy in reset", 128'(busy), 128'd0);
        chk(done === 1'b0, "R10 done in reset", 128'(done), 128'd0);
        chk(result === '0, "R10 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && result === '0,
            "R10 state after reset", result, '0);

        do_mul(SEQV, IDENT, 1'b0, "R9 A*I");
        chk(result === SEQV, "R9 A*I equals A", result, SEQV);
        do_mul(IDENT, SEQV, 1'b0, "R9 I*B");
        chk(result === SEQV, "R9 I*B equals B", result, SEQV);
        do_mul({128{1'b1}}, {128{1'b1}}, 1'b0, "R8 all ones");
        chk(result === {16{8'h04}}, "R8 wrap value", result, {16{8'h04}});
        do_mul('0, rnd128(), 1'b0, "R7 zero after nonzero");
        chk(result === '0, "R7 accumulator cleared", result, '0);
        do_mul(SEQV, SEQV, 1'b1, "R5 disturbed run");

        for (int t = 0; t < 40; t++) begin
            do_mul(rnd128(), rnd128(), (t % 5) == 0, "R1 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule